// File: doc/BRIEF.md
# Seven-Channel Legacy DMA Request Engine

This block gives a chip one shared request, arbitration and address/count engine for eight DMA channel slots, arranged as two cascaded groups of four. Slots 0 to 3 form the byte group and each moves one byte per transfer. Slots 5 to 7 belong to the word group and each moves a 16-bit word per transfer. Slot 4 is the word group's cascade position. It carries no data, and the whole byte group arbitrates from it. Peripherals raise and drop their requests with short frames on a single serial request line. The engine turns these frames into per-channel request levels.

A host programs each channel through a small register port. Each channel has a base and current address, a base and current count, a mode and a mask. The engine picks one unmasked, requesting channel. It then presents one transfer at a time to a bus engine: channel, address, width, memory strobe direction and terminal-count flag. It waits for the bus engine's acknowledge before it advances. Single, demand, verify, auto-initialize and decrementing-address operation are all supported.

Top module: `dma_req_engine`

## Requirements
- R1: A request frame on `dreq_line` is a low start bit, then three channel-number bits (MSB first), then one level bit (1 = request, 0 = withdraw), sampled on consecutive clock edges. The line idles high. A frame naming slot 4 changes nothing and never produces a transfer.
- R2: Among unmasked requesting channels, the order is 0, 1, 2, 3, 5, 6, 7. The byte group as a whole sits in the word group's slot-4 position. Arbitration happens only while no transfer is presented, and a granted channel is not pre-empted.
- R3: Register address `{chan[2:0], field[2:0]}`, with fields 0 = base address, 1 = base count, 2 = mode, 3 = mask (bit 0), 4 = current address (read), 5 = current count (read), 6 = status (bit n = channel n). Writing field 0 or 1 loads both base and current. After reset all masks read 1 and every other field reads 0. Slot 4 reads 0 in every field except status, and writes to it are ignored.
- R4: Byte channels present the current address zero-extended to 17 bits with `xfer_word` low. Word channels present the current address shifted left by one with `xfer_word` high.
- R5: Mode bits [1:0] select the kind: 01 raises `xfer_mem_wr`, 10 raises `xfer_mem_rd`, and 00 or 11 (verify) raises neither. In every kind the address and count still step.
- R6: With mode bit 4 clear (single), a grant carries exactly one transfer. `xfer_valid` is low in the cycle after its acknowledge.
- R7: With mode bit 4 set (demand), transfers continue back to back while the channel's request level stays 1. The engine releases after the acknowledge that finds the request withdrawn.
- R8: A presented transfer holds channel and address steady until `xfer_ack`. Each acknowledge decrements the count, and increments the address, or decrements it when mode bit 3 is set (16-bit wrap).
- R9: `xfer_tc` is high for the transfer whose count is 0. Its acknowledge wraps the count to FFFF, sets the channel's status bit and ends the grant.
- R10: At terminal count a channel without auto-initialize (mode bit 2) sets its mask. With auto-initialize it reloads current address and count from base and leaves the mask as it was.
- R11: Writing field 6 clears each status bit whose data bit is 1.
- R12: The clock edge that samples a frame's level bit updates the request. `xfer_valid` for that channel rises on the following edge if the engine was idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq_line | input | 1 | Serial request line, idle high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address {channel, field} |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| xfer_valid | output | 1 | A transfer is presented |
| xfer_chan | output | 3 | Channel of the presented transfer |
| xfer_addr | output | 17 | Transfer address (word channels shifted) |
| xfer_word | output | 1 | 16-bit transfer |
| xfer_mem_rd | output | 1 | Memory read strobe |
| xfer_mem_wr | output | 1 | Memory write strobe |
| xfer_tc | output | 1 | This transfer reaches terminal count |
| xfer_ack | input | 1 | Bus engine completes the presented transfer |

## Verification
A request takes effect on the edge that samples its level bit, and the grant shows on `xfer_valid` one edge later. Address, count, status and mask move on the edge that samples `xfer_ack`, and a single-mode grant drops on that same edge. The bench drives every input on the falling edge. A behavioural model updates on the rising edge from the same inputs, and every transfer output is compared with the model at each falling edge, half a cycle after the registers move. Register readbacks are sampled 1 ns after the address is set, and the request-latency checks sample on the exact falling edges given by this count.

// File: rtl/dmaq_pkg.sv
`timescale 1ns/1ps
package dmaq_pkg;
    localparam int NCH     = 8;
    localparam int RSV_CH  = 4;
    localparam int ADDR_W  = 16;
    localparam int CNT_W   = 16;

    typedef enum logic [1:0] {
        XF_VERIFY   = 2'b00,
        XF_TO_MEM   = 2'b01,
        XF_FROM_MEM = 2'b10,
        XF_SPARE    = 2'b11
    } xfer_e;

    typedef struct packed {
        logic  demand;
        logic  dec;
        logic  autoinit;
        xfer_e kind;
    } chmode_t;

    typedef enum logic [2:0] {
        F_ADDR  = 3'd0,
        F_CNT   = 3'd1,
        F_MODE  = 3'd2,
        F_MASK  = 3'd3,
        F_CADDR = 3'd4,
        F_CCNT  = 3'd5,
        F_STAT  = 3'd6,
        F_NONE  = 3'd7
    } field_e;

    typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} eng_e;

    function automatic logic moves_data(input xfer_e k);
        return (k == XF_TO_MEM) || (k == XF_FROM_MEM);
    endfunction
endpackage

// File: rtl/dmaq_serreq.sv
`timescale 1ns/1ps
module dmaq_serreq
    import dmaq_pkg::*;
#(
    parameter int N    = NCH,
    parameter int RSVD = RSV_CH,
    localparam int IW  = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line,
    output logic [N-1:0] req
);
    logic          busy;
    logic [3:0]    nbit;
    logic [IW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            nbit <= '0;
            sh   <= '0;
            req  <= '0;
        end else if (!busy) begin
            if (!line) begin
                busy <= 1'b1;
                nbit <= '0;
            end
        end else if (nbit < 4'(IW)) begin
            sh   <= {sh[IW-2:0], line};
            nbit <= nbit + 4'd1;
        end else begin
            busy <= 1'b0;
            if (int'(sh) != RSVD) req[sh] <= line;
        end
    end
endmodule

// File: rtl/dmaq_prio.sv
`timescale 1ns/1ps
module dmaq_prio #(
    parameter int N   = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dmaq_chan.sv
`timescale 1ns/1ps
module dmaq_chan
    import dmaq_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int CW  = CNT_W,
    localparam int DW = (AW > CW) ? AW : CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wdata,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          wr_mode,
    input  logic          wr_mask,
    input  logic          clr_stat,
    input  logic          step,
    output logic [AW-1:0] base_addr,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] base_cnt,
    output logic [CW-1:0] cur_cnt,
    output chmode_t       mode,
    output logic          mask,
    output logic          stat,
    output logic          at_tc
);
    assign at_tc = (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
            mask      <= 1'b1;
            stat      <= 1'b0;
        end else begin
            if (clr_stat) stat <= 1'b0;
            if (step) begin
                cur_cnt  <= cur_cnt - 1'b1;
                cur_addr <= mode.dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
                if (at_tc) begin
                    stat <= 1'b1;
                    if (mode.autoinit) begin
                        cur_addr <= base_addr;
                        cur_cnt  <= base_cnt;
                    end else begin
                        mask <= 1'b1;
                    end
                end
            end
            if (wr_addr) begin
                base_addr <= wdata[AW-1:0];
                cur_addr  <= wdata[AW-1:0];
            end
            if (wr_cnt) begin
                base_cnt <= wdata[CW-1:0];
                cur_cnt  <= wdata[CW-1:0];
            end
            if (wr_mode) mode <= chmode_t'(wdata[$bits(chmode_t)-1:0]);
            if (wr_mask) mask <= wdata[0];
        end
    end

    // R10: terminal count without auto-initialize masks the channel and flags it
    p_tc_masks_r10: assert property (@(posedge clk) disable iff (rst)
        step && at_tc && !mode.autoinit && !wr_mask && !wr_mode |=> mask && stat);

    // R10: terminal count with auto-initialize restores the base values
    p_reload_r10: assert property (@(posedge clk) disable iff (rst)
        step && at_tc && mode.autoinit && !wr_addr && !wr_cnt && !wr_mode
        |=> cur_addr == base_addr && cur_cnt == base_cnt);

    // R9: count wraps to all ones at terminal count
    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        step && at_tc && !mode.autoinit && !wr_cnt && !wr_mode |=> cur_cnt == '1);
endmodule

// File: rtl/dma_req_engine.sv
`timescale 1ns/1ps
module dma_req_engine
    import dmaq_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int CW   = CNT_W,
    localparam int DW  = (AW > CW) ? AW : CW,
    localparam int CHW = $clog2(NCH),
    localparam int HALF = NCH / 2,
    localparam int GW  = $clog2(HALF)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dreq_line,
    input  logic            reg_we,
    input  logic [CHW+2:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            xfer_valid,
    output logic [CHW-1:0]  xfer_chan,
    output logic [AW:0]     xfer_addr,
    output logic            xfer_word,
    output logic            xfer_mem_rd,
    output logic            xfer_mem_wr,
    output logic            xfer_tc,
    input  logic            xfer_ack
);
    logic [NCH-1:0]         req;
    logic [NCH-1:0][AW-1:0] c_base_a, c_cur_a;
    logic [NCH-1:0][CW-1:0] c_base_c, c_cur_c;
    chmode_t [NCH-1:0]      c_mode;
    logic [NCH-1:0]         c_mask, c_stat, c_tc, c_step, elig;

    eng_e           state;
    logic [CHW-1:0] cur_ch;
    logic [CHW-1:0] rch;
    field_e         fld;

    assign rch = reg_addr[CHW+2:3];
    assign fld = field_e'(reg_addr[2:0]);

    dmaq_serreq #(.N(NCH), .RSVD(RSV_CH)) u_serreq (
        .clk(clk), .rst(rst), .line(dreq_line), .req(req)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == RSV_CH) begin : g_rsvd
            assign c_base_a[c] = '0;
            assign c_cur_a[c]  = '0;
            assign c_base_c[c] = '0;
            assign c_cur_c[c]  = '0;
            assign c_mode[c]   = '0;
            assign c_mask[c]   = 1'b0;
            assign c_stat[c]   = 1'b0;
            assign c_tc[c]     = 1'b0;
            assign c_step[c]   = 1'b0;
            assign elig[c]     = 1'b0;
        end else begin : g_live
            logic sel;
            assign sel       = reg_we && (rch == CHW'(c));
            assign c_step[c] = (state == ST_XFER) && xfer_ack && (cur_ch == CHW'(c));
            assign elig[c]   = req[c] && !c_mask[c];
            dmaq_chan #(.AW(AW), .CW(CW)) u_chan (
                .clk(clk), .rst(rst), .wdata(reg_wdata),
                .wr_addr (sel && fld == F_ADDR),
                .wr_cnt  (sel && fld == F_CNT),
                .wr_mode (sel && fld == F_MODE),
                .wr_mask (sel && fld == F_MASK),
                .clr_stat(reg_we && fld == F_STAT && reg_wdata[c]),
                .step    (c_step[c]),
                .base_addr(c_base_a[c]), .cur_addr(c_cur_a[c]),
                .base_cnt(c_base_c[c]),  .cur_cnt(c_cur_c[c]),
                .mode(c_mode[c]), .mask(c_mask[c]), .stat(c_stat[c]), .at_tc(c_tc[c])
            );
        end
    end

    // Byte group arbitrates first, then competes from the cascade slot of the word group.
    logic          b_any, w_any;
    logic [GW-1:0] b_idx, w_idx;
    logic [CHW-1:0] win_ch;

    dmaq_prio #(.N(HALF)) u_byte_prio (.req(elig[HALF-1:0]), .any(b_any), .idx(b_idx));
    dmaq_prio #(.N(HALF)) u_word_prio (.req({elig[NCH-1:HALF+1], b_any}), .any(w_any), .idx(w_idx));

    assign win_ch = (w_idx == '0) ? {1'b0, b_idx} : {1'b1, w_idx};

    chmode_t sel_mode;
    logic    sel_tc;
    assign sel_mode = c_mode[cur_ch];
    assign sel_tc   = c_tc[cur_ch];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
        end else begin
            case (state)
                ST_IDLE: if (w_any) begin
                    state  <= ST_XFER;
                    cur_ch <= win_ch;
                end
                ST_XFER: if (xfer_ack && (sel_tc || !sel_mode.demand || !req[cur_ch]))
                    state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        xfer_valid  = (state == ST_XFER);
        xfer_chan   = cur_ch;
        xfer_word   = cur_ch[CHW-1];
        xfer_addr   = xfer_word ? {c_cur_a[cur_ch], 1'b0} : {1'b0, c_cur_a[cur_ch]};
        xfer_mem_rd = xfer_valid && (sel_mode.kind == XF_FROM_MEM);
        xfer_mem_wr = xfer_valid && (sel_mode.kind == XF_TO_MEM);
        xfer_tc     = xfer_valid && sel_tc;
    end

    always_comb begin
        case (fld)
            F_ADDR:  reg_rdata = DW'(c_base_a[rch]);
            F_CNT:   reg_rdata = DW'(c_base_c[rch]);
            F_MODE:  reg_rdata = DW'(c_mode[rch]);
            F_MASK:  reg_rdata = DW'(c_mask[rch]);
            F_CADDR: reg_rdata = DW'(c_cur_a[rch]);
            F_CCNT:  reg_rdata = DW'(c_cur_c[rch]);
            F_STAT:  reg_rdata = DW'(c_stat);
            default: reg_rdata = '0;
        endcase
    end

    p_no_rsvd_grant_r1: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> xfer_chan != CHW'(RSV_CH));

    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !xfer_ack && !reg_we |=> xfer_valid && $stable(xfer_chan) && $stable(xfer_addr));

    p_single_release_r6: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && xfer_ack && !sel_mode.demand |=> !xfer_valid);

    p_tc_release_r9: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && xfer_ack && xfer_tc |=> !xfer_valid);

    p_verify_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !moves_data(sel_mode.kind) |-> !xfer_mem_rd && !xfer_mem_wr);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xfer_mem_rd, xfer_mem_wr}));

    p_word_even_r4: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && xfer_word |-> !xfer_addr[0]);
endmodule

// File: tb/dma_req_engine_bench.sv
`timescale 1ns/1ps
module dma_req_engine_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic        dreq_line = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        xfer_valid, xfer_word, xfer_mem_rd, xfer_mem_wr, xfer_tc;
    logic [2:0]  xfer_chan;
    logic [16:0] xfer_addr;
    logic        xfer_ack = 1'b0;

    dma_req_engine u_dma_req_engine (
        .clk(clk), .rst(rst), .dreq_line(dreq_line),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_valid(xfer_valid), .xfer_chan(xfer_chan), .xfer_addr(xfer_addr),
        .xfer_word(xfer_word), .xfer_mem_rd(xfer_mem_rd), .xfer_mem_wr(xfer_mem_wr),
        .xfer_tc(xfer_tc), .xfer_ack(xfer_ack)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 0;
    int ack_mode = 0;
    int cyc = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_ba[8], m_ca[8], m_bc[8], m_cc[8], m_md[8];
    bit m_mk[8], m_st[8], m_rq[8];
    bit m_act;
    int m_ch;
    int order[7] = '{0, 1, 2, 3, 5, 6, 7};
    bit g_found, g_tc;
    int g_ch, w_ch, w_f;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_md[i] = 0;
                m_mk[i] = (i != 4); m_st[i] = 0; m_rq[i] = 0;
            end
            m_act = 0; m_ch = 0;
        end else begin
            g_found = 0; g_ch = 0;
            if (!m_act)
                for (int k = 0; k < 7; k++)
                    if (!g_found && m_rq[order[k]] && !m_mk[order[k]]) begin
                        g_found = 1; g_ch = order[k];
                    end
            w_ch = int'(reg_addr[5:3]); w_f = int'(reg_addr[2:0]);
            if (reg_we && w_f == 6)
                for (int i = 0; i < 8; i++) if (reg_wdata[i]) m_st[i] = 0;
            if (m_act && xfer_ack) begin
                g_tc = (m_cc[m_ch] == 0);
                m_cc[m_ch] = (m_cc[m_ch] - 1) & 'hFFFF;
                m_ca[m_ch] = ((m_md[m_ch] & 8) != 0) ? (m_ca[m_ch] - 1) & 'hFFFF : (m_ca[m_ch] + 1) & 'hFFFF;
                if (g_tc) begin
                    m_st[m_ch] = 1;
                    if ((m_md[m_ch] & 4) != 0) begin
                        m_ca[m_ch] = m_ba[m_ch]; m_cc[m_ch] = m_bc[m_ch];
                    end else m_mk[m_ch] = 1;
                end
                if (g_tc || (m_md[m_ch] & 16) == 0 || !m_rq[m_ch]) m_act = 0;
            end
            if (g_found) begin m_act = 1; m_ch = g_ch; end
            if (reg_we && w_ch != 4) begin
                case (w_f)
                    0: begin m_ba[w_ch] = int'(reg_wdata); m_ca[w_ch] = int'(reg_wdata); end
                    1: begin m_bc[w_ch] = int'(reg_wdata); m_cc[w_ch] = int'(reg_wdata); end
                    2: m_md[w_ch] = int'(reg_wdata[4:0]);
                    3: m_mk[w_ch] = reg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison of the transfer outputs (R4 R5 R8 R9)
    logic [22:0] exp_v, act_v;
    int ek;
    always @(negedge clk) begin
        if (cmp_on) begin
            if (!m_act) begin
                chk("R8 idle valid", 32'(xfer_valid), 32'd0);
            end else begin
                ek = m_md[m_ch] & 3;
                exp_v = {1'b1, 3'(m_ch), (m_ch >= 4) ? 17'(m_ca[m_ch] << 1) : 17'(m_ca[m_ch]),
                         (m_ch >= 4), (ek == 2), (ek == 1)};
                act_v = {xfer_valid, xfer_chan, xfer_addr, xfer_word, xfer_mem_rd, xfer_mem_wr};
                chk("R4/R5/R8 transfer", 32'(act_v), 32'(exp_v));
                chk("R9 tc flag", 32'(xfer_tc), 32'(m_cc[m_ch] == 0));
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        case (ack_mode)
            0: xfer_ack <= 1'b1;
            1: xfer_ack <= (cyc % 3 == 0);
            default: xfer_ack <= 1'b0;
        endcase
    end

    task automatic wr(int ch, int f, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(ch * 8 + f); reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int ch, int f, output logic [15:0] v);
        @(negedge clk);
        reg_addr = 6'(ch * 8 + f);
        #1 v = reg_rdata;
    endtask

    task automatic send_req(int ch, bit lvl);
        @(negedge clk) dreq_line = 1'b0;
        for (int b = 2; b >= 0; b--) begin
            @(negedge clk) dreq_line = ((ch >> b) & 1) != 0;
        end
        @(negedge clk) dreq_line = lvl;
        @(negedge clk) dreq_line = 1'b1;
        if (ch != 4) m_rq[ch] = lvl;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] m_stat();
        logic [15:0] s = '0;
        for (int i = 0; i < 8; i++) s[i] = m_st[i];
        return s;
    endfunction

    logic [15:0] v;
    int lim;

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1;
        // R3 reset state
        rd(0, 3, v); chk("R3 reset mask ch0", 32'(v), 32'd1);
        rd(7, 3, v); chk("R3 reset mask ch7", 32'(v), 32'd1);
        rd(0, 6, v); chk("R3 reset status", 32'(v), 32'd0);
        rd(5, 2, v); chk("R3 reset mode ch5", 32'(v), 32'd0);
        chk("R3 reset valid", 32'(xfer_valid), 32'd0);

        // Byte channel, single mode, memory write, count 2
        ack_mode = 0;
        wr(1, 0, 'h1000); wr(1, 1, 2); wr(1, 2, 'h01); wr(1, 3, 0);
        rd(1, 0, v); chk("R3 base address readback", 32'(v), 32'h1000);
        send_req(1, 1);
        chk("R12 no grant yet", 32'(xfer_valid), 32'd0);
        @(negedge clk);
        chk("R1 R12 grant ch1", 32'({xfer_valid, xfer_chan}), 32'({1'b1, 3'd1}));
        chk("R4 byte addr", 32'(xfer_addr), 32'h1000);
        @(negedge clk);
        chk("R6 single releases", 32'(xfer_valid), 32'd0);
        idle(12);
        rd(1, 5, v); chk("R9 count wraps", 32'(v), 32'hFFFF);
        rd(1, 4, v); chk("R8 address stepped", 32'(v), 32'h1003);
        rd(1, 3, v); chk("R10 masked at tc", 32'(v), 32'd1);
        rd(1, 6, v); chk("R9 status set", 32'(v), 32'h0002);
        send_req(1, 0);
        wr(2, 6, 'h0002);
        rd(0, 6, v); chk("R11 status cleared", 32'(v), 32'd0);

        // Word channel, demand mode, memory read, slow acknowledges
        ack_mode = 1;
        wr(5, 0, 'h0800); wr(5, 1, 20); wr(5, 2, 'h12); wr(5, 3, 0);
        send_req(5, 1);
        idle(8);
        chk("R7 demand continues", 32'(xfer_valid), 32'd1);
        chk("R4 word flag", 32'(xfer_word), 32'd1);
        chk("R5 memory read strobe", 32'({xfer_mem_rd, xfer_mem_wr}), 32'b10);
        send_req(5, 0);
        idle(8);
        chk("R7 demand released", 32'(xfer_valid), 32'd0);
        rd(5, 5, v); chk("R8 count vs model", 32'(v), 32'(m_cc[5]));
        rd(5, 4, v); chk("R8 address vs model", 32'(v), 32'(m_ca[5]));
        wr(5, 3, 1);

        // Priority: ch0 stalls while ch7 then ch2 request
        ack_mode = 2;
        wr(0, 0, 'h0010); wr(0, 1, 0); wr(0, 2, 'h11); wr(0, 3, 0);
        wr(2, 0, 'h2000); wr(2, 1, 3); wr(2, 2, 'h00); wr(2, 3, 0);
        wr(7, 0, 'h0200); wr(7, 1, 3); wr(7, 2, 'h01); wr(7, 3, 0);
        send_req(0, 1);
        @(negedge clk);
        chk("R9 tc on count zero", 32'({xfer_valid, xfer_chan, xfer_tc}), 32'({1'b1, 3'd0, 1'b1}));
        send_req(7, 1);
        send_req(2, 1);
        idle(2);
        chk("R8 held without ack", 32'({xfer_valid, xfer_chan}), 32'({1'b1, 3'd0}));
        ack_mode = 0;
        lim = 0;
        while (!(xfer_valid && xfer_chan != 3'd0) && lim < 20) begin
            @(negedge clk); lim++;
        end
        chk("R2 ch2 beats ch7", 32'(xfer_chan), 32'd2);
        chk("R5 verify no strobe", 32'({xfer_mem_rd, xfer_mem_wr}), 32'd0);
        idle(40);
        rd(7, 3, v); chk("R10 ch7 masked", 32'(v), 32'd1);
        rd(0, 6, v); chk("R9 status vs model", 32'(v), 32'(m_stat()));
        send_req(2, 0); send_req(7, 0);

        // Auto-initialize, verify, single
        wr(3, 0, 'h3000); wr(3, 1, 1); wr(3, 2, 'h04); wr(3, 3, 0);
        send_req(3, 1);
        idle(12);
        send_req(3, 0);
        idle(6);
        rd(3, 3, v); chk("R10 autoinit keeps mask", 32'(v), 32'd0);
        rd(3, 4, v); chk("R10 address vs model", 32'(v), 32'(m_ca[3]));
        rd(3, 5, v); chk("R10 count vs model", 32'(v), 32'(m_cc[3]));
        rd(0, 6, v); chk("R9 ch3 status", 32'(v[3]), 32'd1);
        wr(3, 3, 1);

        // Decrementing word channel, demand, memory write
        wr(6, 0, 'h0100); wr(6, 1, 2); wr(6, 2, 'h19); wr(6, 3, 0);
        send_req(6, 1);
        idle(10);
        rd(6, 4, v); chk("R8 decrement address", 32'(v), 32'h00FD);
        rd(6, 5, v); chk("R9 ch6 count wraps", 32'(v), 32'hFFFF);
        send_req(6, 0);

        // Reserved slot 4
        wr(4, 0, 'h1234); wr(4, 3, 0); wr(4, 2, 'h11);
        rd(4, 0, v); chk("R3 slot4 address reads 0", 32'(v), 32'd0);
        rd(4, 2, v); chk("R3 slot4 mode reads 0", 32'(v), 32'd0);
        send_req(4, 1);
        idle(6);
        chk("R1 slot4 frame ignored", 32'(xfer_valid), 32'd0);

        idle(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule